// File: doc/BRIEF.md
# Mixed-Mode 4-bit Block Dot-Product Accumulator

This block takes two streams of 4-bit elements, one pair per clock, and forms the exact dot product of a block of them. Each operand stream carries its own 8-bit block scale. The top bit of that byte says how the operand's elements are read: as a small float with two exponent bits and one mantissa bit, or as a 4-bit signed integer. The two operands are decoded independently, so a float block can be multiplied against an integer block. Both encodings are mapped to one signed fixed-point form in half units, so every element is represented exactly. A single multiplier and adder serve every format pair.

On the beat marked last, the running sum of products is closed. The sum is multiplied by both decoded scales, each with a 4-bit exponent and a 3-bit mantissa. The exact block result appears one clock later as a wide fixed-point number with 20 fractional bits. The same result is added into a running accumulator, which can be cleared. A scale pattern that encodes not-a-number yields a flagged, zeroed result and leaves the accumulator as it was.

Top module: `mx4_dot_mac`

## Requirements
- R1: When a block's scale bit 7 is 0, each of its elements is read as a float: bit 3 is the sign, bits 2:1 the exponent E and bit 0 the mantissa M. The magnitude is M/2 for E=0 and (1+M/2)*2^(E-1) otherwise, giving 0, 0.5, 1, 1.5, 2, 3, 4 or 6.
- R2: When a block's scale bit 7 is 1, each of its elements is a two's-complement integer. Code 1000 is read as -7, so the range is -7..+7.
- R3: The format of each operand is chosen from that operand's own scale bit 7, on every beat. Float-by-integer and integer-by-float blocks therefore give the exact mixed products.
- R4: Scale bits 6:3 are an exponent e and bits 2:0 a mantissa m, with bias 7. The scale is (1+m/8)*2^(e-7) for e>0 and (m/8)*2^-6 for e=0. The block result is the exact sum of element products times both scales at the closing beat. It is given in two's complement with 20 fractional bits and 51 bits total, with no overflow for 16-element blocks.
- R5: res_valid is high for exactly the one cycle after a beat with in_valid and in_last both high. res_value holds the block result from that cycle until the next block closes.
- R6: Every closing beat without a NaN scale adds its block result to acc_value. The next block's sum starts from zero.
- R7: clr zeroes acc_value and err_flag. If clr arrives together with a closing beat, acc_value takes that block's result alone.
- R8: If the low 7 bits of either scale are all ones at the closing beat, res_nan pulses with res_valid and res_value is 0. acc_value is unchanged, and err_flag is set and stays set until clr.
- R9: Cycles with in_valid low change neither the partial sum nor any output, whatever the element inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Clears accumulator and error flag |
| in_valid | input | 1 | Element pair present this cycle |
| in_last | input | 1 | This pair closes the block |
| a_elem | input | 4 | Element of operand A |
| b_elem | input | 4 | Element of operand B |
| a_scale | input | 8 | Block scale of A; bit 7 selects integer format |
| b_scale | input | 8 | Block scale of B; bit 7 selects integer format |
| res_valid | output | 1 | Block result valid pulse |
| res_nan | output | 1 | Block closed with a NaN scale |
| res_value | output | 51 | Block result, 20 fractional bits |
| acc_value | output | ACC_W (64) | Running accumulator, 20 fractional bits |
| err_flag | output | 1 | Sticky NaN indication |

## Verification
All results come one rising edge after the closing beat. That edge registers res_valid, res_nan and res_value and updates acc_value and err_flag. The bench changes inputs on the falling edge. It reads every result on the falling edge right after the closing beat's rising edge. One falling edge later it checks that the valid pulse has dropped. Clears given without a closing beat are read back one falling edge after their rising edge.

// File: rtl/mx4_pkg.sv
package mx4_pkg;
   localparam int ELEM_W    = 4;
   localparam int DEC_W     = 5;            // half units, -14..14
   localparam int PROD_W    = 2 * DEC_W;    // quarter units
   localparam int SIG_W     = 4;            // scale significand with hidden bit
   localparam int EXQ_W     = 4;            // effective scale exponent 1..15
   localparam int SCL_W     = 2 * SIG_W;
   localparam int SHIFT_MAX = 2 * 15 - 2;
   localparam int FRAC_BITS = 20;
   localparam int PROD_MAX  = 196;          // 14 * 14 in quarter units

   typedef struct packed {
      logic             int_mode;
      logic             nan;
      logic [SIG_W-1:0] sig;
      logic [EXQ_W-1:0] exq;
   } scale_t;
endpackage

// File: rtl/mx4_scale_dec.sv
module mx4_scale_dec
   import mx4_pkg::*;
(
   input  logic [7:0] sbyte,
   output scale_t     dec
);
   logic [3:0] e_f;
   logic [2:0] m_f;

   assign e_f = sbyte[6:3];
   assign m_f = sbyte[2:0];

   always_comb begin
      dec.int_mode = sbyte[7];
      dec.nan      = (sbyte[6:0] == 7'h7F);
      if (e_f == 4'd0) begin
         dec.sig = {1'b0, m_f};
         dec.exq = 4'd1;
      end else begin
         dec.sig = {1'b1, m_f};
         dec.exq = e_f;
      end
   end

   always_comb begin
      // R4
      scale_exp_chk: assert (dec.exq != 4'd0);
   end
endmodule

// File: rtl/mx4_elem_dec.sv
module mx4_elem_dec
   import mx4_pkg::*;
(
   input  logic [ELEM_W-1:0]       code,
   input  logic                    int_mode,
   output logic signed [DEC_W-1:0] half_val
);
   logic [3:0] fp_mag;
   logic [3:0] fp_base;

   assign fp_base = 4'd2 + {3'b000, code[0]};

   always_comb begin
      case (code[2:1])
         2'd0:    fp_mag = {3'b000, code[0]};
         2'd1:    fp_mag = fp_base;
         2'd2:    fp_mag = fp_base << 1;
         default: fp_mag = fp_base << 2;
      endcase
   end

   always_comb begin
      if (int_mode) begin
         if (code == 4'b1000) half_val = -5'sd14;
         else                 half_val = $signed({code, 1'b0});
      end else begin
         if (code[3]) half_val = -$signed({1'b0, fp_mag});
         else         half_val =  $signed({1'b0, fp_mag});
      end
   end

   always_comb begin
      // R2
      int_range_chk: assert (!int_mode || (half_val >= -5'sd14 && half_val <= 5'sd14));
      // R1
      fp_range_chk: assert (int_mode || (half_val >= -5'sd12 && half_val <= 5'sd12));
   end
endmodule

// File: rtl/mx4_lane.sv
module mx4_lane
   import mx4_pkg::*;
#(
   parameter int N_ELEM = 16,
   localparam int SUM_W = PROD_W + $clog2(N_ELEM)
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic                    in_last,
   input  logic signed [DEC_W-1:0] a_val,
   input  logic signed [DEC_W-1:0] b_val,
   output logic signed [SUM_W-1:0] sum_close
);
   localparam int BOUND = PROD_MAX * N_ELEM;

   logic signed [PROD_W-1:0] prod;
   logic signed [SUM_W-1:0]  prod_ext;
   logic signed [SUM_W-1:0]  sum_q;

   assign prod      = a_val * b_val;
   assign prod_ext  = {{(SUM_W-PROD_W){prod[PROD_W-1]}}, prod};
   assign sum_close = sum_q + prod_ext;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q <= '0;
      end else if (in_valid) begin
         if (in_last) sum_q <= '0;
         else         sum_q <= sum_close;
      end
   end

   // R4
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(sum_q) <= BOUND) && (int'(sum_q) >= -BOUND));

   // R9
   idle_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(sum_q));
endmodule

// File: rtl/mx4_dot_mac.sv
module mx4_dot_mac
   import mx4_pkg::*;
#(
   parameter int N_ELEM = 16,
   parameter int ACC_W  = 64,
   localparam int SUM_W = PROD_W + $clog2(N_ELEM),
   localparam int RES_W = SUM_W + SCL_W + SHIFT_MAX + 1
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    in_valid,
   input  logic                    in_last,
   input  logic [3:0]              a_elem,
   input  logic [3:0]              b_elem,
   input  logic [7:0]              a_scale,
   input  logic [7:0]              b_scale,
   output logic                    res_valid,
   output logic                    res_nan,
   output logic signed [RES_W-1:0] res_value,
   output logic signed [ACC_W-1:0] acc_value,
   output logic                    err_flag
);
   generate
      if (N_ELEM < 2) begin : g_bad_len
         $error("mx4_dot_mac: N_ELEM must be at least 2");
      end
      if (ACC_W < RES_W) begin : g_bad_acc
         $error("mx4_dot_mac: ACC_W narrower than block result");
      end
   endgenerate

   logic [1:0][ELEM_W-1:0]  elem_in;
   logic [1:0][7:0]         scl_in;
   scale_t                  scl_dec [2];
   logic signed [DEC_W-1:0] dec_val [2];

   assign elem_in = {b_elem, a_elem};
   assign scl_in  = {b_scale, a_scale};

   generate
      for (genvar g = 0; g < 2; g++) begin : g_op
         mx4_scale_dec u_scale (
            .sbyte (scl_in[g]),
            .dec   (scl_dec[g])
         );
         mx4_elem_dec u_elem (
            .code     (elem_in[g]),
            .int_mode (scl_dec[g].int_mode),
            .half_val (dec_val[g])
         );
      end
   endgenerate

   logic signed [SUM_W-1:0] sum_close;

   mx4_lane #(.N_ELEM(N_ELEM)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_last   (in_last),
      .a_val     (dec_val[0]),
      .b_val     (dec_val[1]),
      .sum_close (sum_close)
   );

   logic [SCL_W-1:0]        scl_prod;
   logic [4:0]              shamt;
   logic signed [RES_W-1:0] sum_ext;
   logic signed [RES_W-1:0] scl_ext;
   logic signed [RES_W-1:0] blk_val;
   logic signed [ACC_W-1:0] blk_ext;
   logic                    blk_nan;
   logic                    close;

   assign scl_prod = SCL_W'(scl_dec[0].sig) * SCL_W'(scl_dec[1].sig);
   assign shamt    = {1'b0, scl_dec[0].exq} + {1'b0, scl_dec[1].exq} - 5'd2;
   assign sum_ext  = {{(RES_W-SUM_W){sum_close[SUM_W-1]}}, sum_close};
   assign scl_ext  = $signed({{(RES_W-SCL_W){1'b0}}, scl_prod});
   assign blk_val  = (sum_ext * scl_ext) <<< shamt;
   assign blk_ext  = {{(ACC_W-RES_W){blk_val[RES_W-1]}}, blk_val};
   assign blk_nan  = scl_dec[0].nan | scl_dec[1].nan;
   assign close    = in_valid & in_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_nan   <= 1'b0;
         res_value <= '0;
         acc_value <= '0;
         err_flag  <= 1'b0;
      end else begin
         res_valid <= close;
         res_nan   <= close & blk_nan;
         if (close) res_value <= blk_nan ? '0 : blk_val;
         if (clr) begin
            acc_value <= (close && !blk_nan) ? blk_ext : '0;
            err_flag  <= close & blk_nan;
         end else begin
            if (close && !blk_nan) acc_value <= acc_value + blk_ext;
            if (close && blk_nan)  err_flag  <= 1'b1;
         end
      end
   end

   // R5
   res_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(in_valid && in_last));

   // R8
   nan_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_nan |-> (res_valid && res_value == '0 && err_flag));

   // R8
   nan_acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_last && blk_nan && !clr) |=> $stable(acc_value));

   // R7
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !(in_valid && in_last)) |=> (acc_value == '0 && !err_flag));

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(in_valid && in_last) && !clr) |=> ($stable(acc_value) && $stable(res_value) && !res_valid));

   // R8
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag && !clr) |=> err_flag);
endmodule

// File: tb/mx4_dot_mac_tb_top.sv
module mx4_dot_mac_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int RES_W = 51;
   localparam int ACC_W = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clr = 1'b0;
   logic in_valid = 1'b0;
   logic in_last = 1'b0;
   logic [3:0] a_elem = '0;
   logic [3:0] b_elem = '0;
   logic [7:0] a_scale = '0;
   logic [7:0] b_scale = '0;
   logic res_valid, res_nan, err_flag;
   logic signed [RES_W-1:0] res_value;
   logic signed [ACC_W-1:0] acc_value;

   always #(CLK_PERIOD/2) clk = ~clk;

   mx4_dot_mac dut_i (
      .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_last(in_last),
      .a_elem(a_elem), .b_elem(b_elem), .a_scale(a_scale), .b_scale(b_scale),
      .res_valid(res_valid), .res_nan(res_nan), .res_value(res_value),
      .acc_value(acc_value), .err_flag(err_flag)
   );

   int n_chk = 0;
   int n_bad = 0;
   longint acc_m = 0;
   bit err_m = 0;
   longint last_res = 0;
   logic [31:0] lfsr = 32'hACE1_2357;

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int fp_half(input logic [3:0] c);
      int mag;
      if (c[2:1] == 2'd0) mag = c[0];
      else                mag = (2 + c[0]) << (c[2:1] - 1);
      return c[3] ? -mag : mag;
   endfunction

   function automatic int int_half(input logic [3:0] c);
      if (c == 4'b1000) return -14;
      return 2 * int'($signed(c));
   endfunction

   function automatic int elem_half(input logic [3:0] c, input logic im);
      return im ? int_half(c) : fp_half(c);
   endfunction

   function automatic longint scale_sig(input logic [7:0] s);
      return (s[6:3] == 0) ? longint'(s[2:0]) : longint'(8 + s[2:0]);
   endfunction

   function automatic int scale_exq(input logic [7:0] s);
      return (s[6:3] == 0) ? 1 : int'(s[6:3]);
   endfunction

   function automatic longint model(input logic [63:0] ap, input logic [63:0] bp,
                                    input logic [7:0] sa, input logic [7:0] sb);
      longint s = 0;
      for (int i = 0; i < 16; i++)
         s += elem_half(ap[4*i +: 4], sa[7]) * elem_half(bp[4*i +: 4], sb[7]);
      return (s * scale_sig(sa) * scale_sig(sb)) <<< (scale_exq(sa) + scale_exq(sb) - 2);
   endfunction

   function automatic logic [31:0] step(input logic [31:0] v);
      return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
   endfunction

   task automatic run_block(input string tag, input logic [63:0] ap, input logic [63:0] bp,
                            input logic [7:0] sa, input logic [7:0] sb,
                            input int gap, input bit clr_last);
      bit nan_m;
      longint exp_v;
      nan_m = (sa[6:0] == 7'h7F) || (sb[6:0] == 7'h7F);
      exp_v = nan_m ? 0 : model(ap, bp, sa, sb);
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_last  = (i == 15);
         clr      = (i == 15) && clr_last;
         a_elem   = ap[4*i +: 4];
         b_elem   = bp[4*i +: 4];
         a_scale  = sa;
         b_scale  = sb;
         if (i < 15) begin
            for (int g = 0; g < gap; g++) begin
               @(negedge clk);
               in_valid = 1'b0;
               in_last  = 1'b1;
               a_elem   = ~a_elem;
               b_elem   = b_elem + 4'd5;
            end
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
      clr      = 1'b0;
      if (clr_last) begin acc_m = 0; err_m = 0; end
      if (nan_m) err_m = 1;
      else begin acc_m += exp_v; last_res = exp_v; end
      if (nan_m) last_res = 0;
      chk({tag, " res_valid"}, longint'(res_valid), 1);
      chk({tag, " res_nan"}, longint'(res_nan), longint'(nan_m));
      chk({tag, " res_value"}, longint'(res_value), exp_v);
      chk({tag, " acc_value"}, acc_value, acc_m);
      chk({tag, " err_flag"}, longint'(err_flag), longint'(err_m));
   endtask

   task automatic t_reset;
      chk("R5 reset res_valid", longint'(res_valid), 0);
      chk("R6 reset acc_value", acc_value, 0);
      chk("R8 reset err_flag", longint'(err_flag), 0);
      chk("R4 reset res_value", longint'(res_value), 0);
   endtask

   task automatic t_fp_codes;
      // R1: every float code times +1.0, both scales 1.0
      run_block("R1 fp codes", 64'hFEDC_BA98_7654_3210, {16{4'h2}}, 8'h38, 8'h38, 0, 0);
      run_block("R1 fp squares", 64'h7654_3210_FEDC_BA98, 64'h7654_3210_FEDC_BA98, 8'h38, 8'h38, 0, 0);
   endtask

   task automatic t_int_codes;
      // R2: integer codes including 1000 against integer +1
      run_block("R2 int codes", 64'hFEDC_BA98_7654_3210, {16{4'h1}}, 8'hB8, 8'hB8, 0, 0);
      run_block("R2 int min", {16{4'h8}}, {16{4'h8}}, 8'hB8, 8'hB8, 0, 0);
   endtask

   task automatic t_mixed;
      // R3: float A by integer B and the reverse
      run_block("R3 fp x int", 64'h7F3A_C519_B26E_0D84, 64'h8F7E_1234_9ABC_DE56, 8'h40, 8'hB1, 0, 0);
      run_block("R3 int x fp", 64'h8F7E_1234_9ABC_DE56, 64'h7F3A_C519_B26E_0D84, 8'hB1, 8'h40, 0, 0);
   endtask

   task automatic t_scales;
      // R4: subnormal, smallest and largest finite scales
      run_block("R4 sub x sub", {16{4'h7}}, {16{4'h7}}, 8'h01, 8'h07, 0, 0);
      run_block("R4 max x max", {16{4'h7}}, {16{4'hF}}, 8'hFE, 8'hFE, 0, 0);
      run_block("R4 zero scale", {16{4'h7}}, {16{4'h7}}, 8'h00, 8'h7E, 0, 0);
      run_block("R4 mixed exp", 64'h0123_4567_89AB_CDEF, 64'h1111_7777_9999_FFFF, 8'h3D, 8'hCA, 0, 0);
   endtask

   task automatic t_pulse;
      // R5: pulse lasts one cycle, value held
      run_block("R5 pulse", 64'h1234_5678_1234_5678, 64'h2222_3333_4444_5555, 8'h38, 8'h38, 0, 0);
      @(negedge clk);
      chk("R5 pulse drop", longint'(res_valid), 0);
      chk("R5 value held", longint'(res_value), last_res);
   endtask

   task automatic t_gaps;
      // R9: idle cycles with toggling elements are ignored
      run_block("R9 gaps", 64'h9A5C_3E71_0B2D_F486, 64'h5A5A_A5A5_3C3C_C3C3, 8'hC4, 8'h35, 2, 0);
      repeat (3) @(negedge clk);
      chk("R9 idle acc", acc_value, acc_m);
      chk("R9 idle valid", longint'(res_valid), 0);
   endtask

   task automatic t_nan;
      // R8: NaN scale on A, then on B
      run_block("R8 nan a", {16{4'h3}}, {16{4'h3}}, 8'h7F, 8'h38, 0, 0);
      run_block("R8 nan b", {16{4'h3}}, {16{4'h3}}, 8'h38, 8'hFF, 0, 0);
      run_block("R8 after nan", {16{4'h2}}, {16{4'h2}}, 8'h38, 8'h38, 0, 0);
   endtask

   task automatic t_clear;
      // R7: standalone clear, then clear with a closing beat
      @(negedge clk);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      acc_m = 0;
      err_m = 0;
      chk("R7 clr acc", acc_value, 0);
      chk("R7 clr err", longint'(err_flag), 0);
      run_block("R7 load", {16{4'h5}}, {16{4'h6}}, 8'h30, 8'hB8, 0, 0);
      run_block("R7 clr with last", 64'hABCD_1234_EF01_5678, {16{4'h3}}, 8'h38, 8'h41, 0, 1);
   endtask

   task automatic t_random;
      // R6: accumulation over varied blocks
      for (int k = 0; k < 8; k++) begin
         logic [63:0] ap, bp;
         logic [7:0] sa, sb;
         lfsr = step(lfsr); ap[31:0] = lfsr;
         lfsr = step(lfsr); ap[63:32] = lfsr;
         lfsr = step(lfsr); bp[31:0] = lfsr;
         lfsr = step(lfsr); bp[63:32] = lfsr;
         lfsr = step(lfsr);
         sa = lfsr[7:0];
         sb = lfsr[15:8];
         if (sa[6:0] == 7'h7F) sa[0] = 1'b0;
         if (sb[6:0] == 7'h7F) sb[0] = 1'b0;
         run_block("R6 accumulate", ap, bp, sa, sb, k % 2, 0);
      end
   endtask

   task automatic finish_run;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fp_codes();
      t_int_codes();
      t_mixed();
      t_scales();
      t_pulse();
      t_gaps();
      t_nan();
      t_clear();
      t_random();
      finish_run();
   end
endmodule